// File: doc/BRIEF.md
# Switch register access bridge

This block sits between a host processor's 32-bit memory-mapped register bus and the paged register file of an Ethernet switch core. The host first obtains ownership through a request/grant handshake in a control word. It then loads up to 64 bits of write data into two data words and writes a command word carrying the page, the register offset, a write/read flag and a go flag. The bridge launches one transaction on the switch side and holds the go flag as a busy indication until the switch returns a completion strobe. For reads, the returned 64-bit value lands in two read-data words. Narrow values (8, 16 or 32 bits) use only the low word. For 48-bit values only the low 16 bits of the high word carry meaning; the bridge itself always moves all 64 bits.

A second word latches single-cycle event pulses from the switch. The host clears these bits by writing ones. The control word also reports whether the switch has finished its initialisation.

Two state machines drive the block. The ownership machine has the states OWN_FREE and OWN_HELD. The transitions are grab (request set, no transaction active) and drop (request cleared). The transaction machine has the states XF_IDLE, XF_LAUNCH and XF_WAIT. The transitions are go (accepted command with go set), issue (always, after one cycle) and complete (completion strobe seen).

Top module: `swreg_bridge`

## Requirements
- R1: After reset every host-visible word reads 0 (except control bit 6, which follows the init input), grant and busy are low, and the switch request and switch reset outputs are low.
- R2: Control word at offset 0x40: bit 3 is request (host-written), bit 4 is grant. Grant rises in the cycle after request is registered if no transaction is active; otherwise it waits until the transaction completes. Grant falls in the cycle after request is cleared.
- R3: Command word at offset 0x2C: bits 31:24 page, bits 23:16 register offset, bit 2 switch reset, bit 1 write (1) or read (0), bit 0 go/busy. A read returns the stored fields, with bit 0 showing busy.
- R4: A command written with bit 0 set while granted and idle starts exactly one transaction. The switch request output pulses for one cycle with page, offset and direction presented. Bit 0 reads 1 from the cycle after the command until the cycle after the completion strobe.
- R5: Write-data words are high at 0x30 and low at 0x34. Both read back. A write transaction presents {high, low} as the 64-bit switch write data and leaves the read-data words unchanged.
- R6: On completion of a read transaction, switch read data bits 31:0 appear at 0x3C and bits 63:32 at 0x38.
- R7: A command or write-data write made while grant is low, or while busy is set, is ignored: no register changes and no transaction starts.
- R8: Control word bit 6 reports the switch-initialisation-done input.
- R9: Event word at 0x44 latches switch pulses in bits 12:0 (bits 7:0 per port, 8 PHY, 9 time sync, 12:10 sleep timers). Writing 1 clears a bit. A pulse in the same cycle as its clear keeps the bit set.
- R10: Command bit 2 is stored when an accepted command is written and drives the switch reset output directly, with no transaction started unless bit 0 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 8 | Host byte address |
| h_wr | input | 1 | Host write enable |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational from address) |
| sw_req | output | 1 | One-cycle transaction start to the switch |
| sw_we | output | 1 | Transaction direction, 1 = write |
| sw_page | output | 8 | Switch register page |
| sw_ofs | output | 8 | Register offset within page |
| sw_wdata | output | 64 | Write data to the switch |
| sw_done | input | 1 | Completion strobe from the switch |
| sw_rdata | input | 64 | Read data, valid with sw_done |
| sw_init_done | input | 1 | Switch initialisation finished |
| sw_evt | input | 13 | Event pulses from the switch |
| sw_reset | output | 1 | Switch reset control |

## Verification
A stuck transaction machine shows at the port as command bit 0 that never clears, or as a missing or repeated switch request pulse, visible within one cycle of the go write. A wrong ownership state shows on control bit 4 one cycle after request changes. It also shows as commands that should be ignored starting a transaction, or as accepted ones that start none. Wrong read capture shows only after completion, in the read-data words. The event latch is checked for set, clear and the clear-versus-pulse collision in the exact cycle.

// File: rtl/swb_pkg.sv
package swb_pkg;
    localparam int HOST_W  = 32;
    localparam int XDATA_W = 64;
    localparam int PAGE_W  = 8;
    localparam int OFS_W   = 8;

    localparam logic [7:0] A_CMD  = 8'h2C;
    localparam logic [7:0] A_WDHI = 8'h30;
    localparam logic [7:0] A_WDLO = 8'h34;
    localparam logic [7:0] A_RDHI = 8'h38;
    localparam logic [7:0] A_RDLO = 8'h3C;
    localparam logic [7:0] A_CTRL = 8'h40;
    localparam logic [7:0] A_EVT  = 8'h44;

    localparam int B_GO   = 0;
    localparam int B_WR   = 1;
    localparam int B_RST  = 2;
    localparam int B_OFS  = 16;
    localparam int B_PAGE = 24;
    localparam int B_REQ  = 3;
    localparam int B_GNT  = 4;
    localparam int B_INIT = 6;

    typedef enum logic [1:0] {XF_IDLE, XF_LAUNCH, XF_WAIT} xfer_state_t;
    typedef enum logic {OWN_FREE, OWN_HELD} own_state_t;
endpackage

// File: rtl/swb_own_arb.sv
module swb_own_arb
    import swb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic xfer_busy,
    output logic grant
);
    own_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OWN_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_FREE: if (req && !xfer_busy) state_d = OWN_HELD;
            OWN_HELD: if (!req)              state_d = OWN_FREE;
            default:                         state_d = OWN_FREE;
        endcase
    end

    always_comb grant = (state_q == OWN_HELD);

    // R2
    grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant && !xfer_busy) |=> grant);
    // R2
    grant_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !grant);
endmodule

// File: rtl/swb_xfer_fsm.sv
module swb_xfer_fsm
    import swb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_write,
    input  logic sw_done,
    output logic busy,
    output logic sw_req,
    output logic rd_capture
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE:   if (start)   state_d = XF_LAUNCH;
            XF_LAUNCH:              state_d = XF_WAIT;
            XF_WAIT:   if (sw_done) state_d = XF_IDLE;
            default:                state_d = XF_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state_q != XF_IDLE);
        sw_req     = (state_q == XF_LAUNCH);
        rd_capture = (state_q == XF_WAIT) && sw_done && !op_write;
    end

    // R4
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> (!sw_req && busy));
    // R4
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> sw_req);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sw_req && sw_done) |=> !busy);
endmodule

// File: rtl/swb_evt_latch.sv
module swb_evt_latch #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= pulse[i] | (flags[i] & ~clr[i]);
        end

        // R9
        evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |=> flags[i]);
        // R9
        evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);
    end
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
    import swb_pkg::*;
#(
    parameter int EVT_N = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          h_addr,
    input  logic                h_wr,
    input  logic [HOST_W-1:0]   h_wdata,
    output logic [HOST_W-1:0]   h_rdata,
    output logic                sw_req,
    output logic                sw_we,
    output logic [PAGE_W-1:0]   sw_page,
    output logic [OFS_W-1:0]    sw_ofs,
    output logic [XDATA_W-1:0]  sw_wdata,
    input  logic                sw_done,
    input  logic [XDATA_W-1:0]  sw_rdata,
    input  logic                sw_init_done,
    input  logic [EVT_N-1:0]    sw_evt,
    output logic                sw_reset
);
    localparam int HALF = XDATA_W / 2;
    localparam int PAD  = HOST_W - EVT_N;

    logic              grant, busy, rd_capture, accept, start;
    logic              req_q, we_q, rst_q;
    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [HALF-1:0]   wd_lo_q, wd_hi_q, rd_lo_q, rd_hi_q;
    logic [EVT_N-1:0]  evt_q, evt_clr;
    logic              wr_cmd, wr_wdlo, wr_wdhi, wr_ctrl, wr_evt;

    always_comb begin
        wr_cmd  = h_wr && (h_addr == A_CMD);
        wr_wdlo = h_wr && (h_addr == A_WDLO);
        wr_wdhi = h_wr && (h_addr == A_WDHI);
        wr_ctrl = h_wr && (h_addr == A_CTRL);
        wr_evt  = h_wr && (h_addr == A_EVT);
        accept  = grant && !busy;
        start   = wr_cmd && accept && h_wdata[B_GO];
        evt_clr = wr_evt ? h_wdata[EVT_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            rst_q   <= 1'b0;
            page_q  <= '0;
            ofs_q   <= '0;
            wd_lo_q <= '0;
            wd_hi_q <= '0;
            rd_lo_q <= '0;
            rd_hi_q <= '0;
        end else begin
            if (wr_ctrl) req_q <= h_wdata[B_REQ];
            if (wr_cmd && accept) begin
                page_q <= h_wdata[B_PAGE +: PAGE_W];
                ofs_q  <= h_wdata[B_OFS +: OFS_W];
                we_q   <= h_wdata[B_WR];
                rst_q  <= h_wdata[B_RST];
            end
            if (wr_wdlo && accept) wd_lo_q <= h_wdata;
            if (wr_wdhi && accept) wd_hi_q <= h_wdata;
            if (rd_capture) begin
                rd_lo_q <= sw_rdata[HALF-1:0];
                rd_hi_q <= sw_rdata[XDATA_W-1:HALF];
            end
        end
    end

    swb_own_arb u_own (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_q),
        .xfer_busy (busy),
        .grant     (grant)
    );

    swb_xfer_fsm u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_write   (we_q),
        .sw_done    (sw_done),
        .busy       (busy),
        .sw_req     (sw_req),
        .rd_capture (rd_capture)
    );

    swb_evt_latch #(.N(EVT_N)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (sw_evt),
        .clr   (evt_clr),
        .flags (evt_q)
    );

    always_comb begin
        sw_we    = we_q;
        sw_page  = page_q;
        sw_ofs   = ofs_q;
        sw_wdata = {wd_hi_q, wd_lo_q};
        sw_reset = rst_q;
    end

    always_comb begin
        h_rdata = '0;
        case (h_addr)
            A_CMD:  h_rdata = {page_q, ofs_q, 13'd0, rst_q, we_q, busy};
            A_WDHI: h_rdata = wd_hi_q;
            A_WDLO: h_rdata = wd_lo_q;
            A_RDHI: h_rdata = rd_hi_q;
            A_RDLO: h_rdata = rd_lo_q;
            A_CTRL: begin
                h_rdata[B_REQ]  = req_q;
                h_rdata[B_GNT]  = grant;
                h_rdata[B_INIT] = sw_init_done;
            end
            A_EVT:  h_rdata = {{PAD{1'b0}}, evt_q};
            default: h_rdata = '0;
        endcase
    end

    // R7
    nogrant_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !grant && !busy) |=> !busy);
    // R7
    busy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_wdlo || wr_wdhi) && busy) |=> ($stable(wd_lo_q) && $stable(wd_hi_q)));
    // R5
    wr_keep_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we_q) |=> ($stable(rd_lo_q) && $stable(rd_hi_q)));
    // R3
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: tb/tb_swreg_bridge.sv
module tb_swreg_bridge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  h_addr;
    logic        h_wr;
    logic [31:0] h_wdata, h_rdata;
    logic        sw_req, sw_we, sw_done, sw_init_done, sw_reset;
    logic [7:0]  sw_page, sw_ofs;
    logic [63:0] sw_wdata, sw_rdata;
    logic [12:0] sw_evt;

    int checks = 0, failures = 0, req_cnt = 0, resp_lat = 3;
    bit finished = 0;
    logic        obs_we;
    logic [7:0]  obs_page, obs_ofs;
    logic [63:0] obs_wdata;
    logic [63:0] model [16];

    always #2 clk = ~clk;

    swreg_bridge dut (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .sw_req(sw_req), .sw_we(sw_we),
        .sw_page(sw_page), .sw_ofs(sw_ofs), .sw_wdata(sw_wdata),
        .sw_done(sw_done), .sw_rdata(sw_rdata), .sw_init_done(sw_init_done),
        .sw_evt(sw_evt), .sw_reset(sw_reset)
    );

    // switch-side responder model
    initial begin
        sw_done = 0; sw_rdata = '0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        forever begin
            @(negedge clk);
            if (rst_n && sw_req) begin
                req_cnt++;
                obs_we = sw_we; obs_page = sw_page; obs_ofs = sw_ofs; obs_wdata = sw_wdata;
                repeat (resp_lat) @(negedge clk);
                sw_done = 1;
                sw_rdata = obs_we ? 64'h0 : model[obs_ofs[3:0]];
                if (obs_we) model[obs_ofs[3:0]] = obs_wdata;
                @(negedge clk);
                sw_done = 0;
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        h_addr = a; h_wr = 1; h_wdata = d;
        @(negedge clk);
        h_wr = 0;
    endtask

    task automatic hr(logic [7:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            hr(8'h2C, v);
            if (v[0] == 1'b0) return;
            @(negedge clk);
        end
        chk("R4 busy never cleared", 64'd1, 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hr(8'h40, v); chk("R1 ctrl", v, 0);
        hr(8'h2C, v); chk("R1 cmd", v, 0);
        hr(8'h44, v); chk("R1 evt", v, 0);
        hr(8'h3C, v); chk("R1 rdlo", v, 0);
        chk("R1 sw_req/sw_reset", {sw_req, sw_reset}, 0);
    endtask

    task automatic t_no_grant();
        logic [31:0] v;
        hw(8'h2C, 32'h1122_0003);
        repeat (4) @(negedge clk);
        hr(8'h2C, v); chk("R7 cmd ignored without grant", v, 0);
        chk("R7 no transaction without grant", req_cnt, 0);
        hw(8'h34, 32'h0000_DEAD);
        hr(8'h34, v); chk("R7 data ignored without grant", v, 0);
    endtask

    task automatic t_grant();
        logic [31:0] v;
        hw(8'h40, 32'h8);
        hr(8'h40, v); chk("R2 request seen, grant not yet", v, 32'h08);
        @(negedge clk);
        hr(8'h40, v); chk("R2 grant next cycle", v, 32'h18);
    endtask

    task automatic t_write();
        logic [31:0] v;
        resp_lat = 3;
        hw(8'h34, 32'hCAFE_0001);
        hw(8'h30, 32'h0000_BEEF);
        hr(8'h30, v); chk("R5 wdhi readback", v, 32'h0000_BEEF);
        hw(8'h2C, 32'h1205_0003);
        hr(8'h2C, v); chk("R3 R4 busy after go", v, 32'h1205_0003);
        wait_idle();
        hr(8'h2C, v); chk("R4 busy cleared", v, 32'h1205_0002);
        chk("R4 one request", req_cnt, 1);
        chk("R5 switch fields", {obs_we, obs_page, obs_ofs}, {1'b1, 8'h12, 8'h05});
        chk("R5 switch wdata", obs_wdata, 64'h0000_BEEF_CAFE_0001);
        hr(8'h3C, v); chk("R5 rd words untouched", v, 0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        hw(8'h2C, 32'h1205_0001);
        wait_idle();
        chk("R6 read direction", obs_we, 0);
        hr(8'h3C, v); chk("R6 rdlo", v, 32'hCAFE_0001);
        hr(8'h38, v); chk("R6 rdhi", v, 32'h0000_BEEF);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        resp_lat = 20;
        hw(8'h2C, 32'h3407_0001);
        hw(8'h2C, 32'h5509_0003);
        hw(8'h34, 32'h0000_0001);
        hr(8'h2C, v); chk("R7 cmd ignored while busy", v, 32'h3407_0001);
        hr(8'h34, v); chk("R7 data ignored while busy", v, 32'hCAFE_0001);
        hw(8'h40, 32'h0);
        hr(8'h40, v); chk("R2 grant held one cycle", v, 32'h10);
        @(negedge clk);
        hr(8'h40, v); chk("R2 grant dropped", v, 32'h00);
        hw(8'h40, 32'h8);
        @(negedge clk); @(negedge clk);
        hr(8'h40, v); chk("R2 no grant while busy", v, 32'h08);
        wait_idle();
        @(negedge clk);
        hr(8'h40, v); chk("R2 grant after completion", v, 32'h18);
        chk("R7 ignored cmd launched nothing", req_cnt, 3);
        hr(8'h3C, v); chk("R6 rdlo of empty reg", v, 0);
        resp_lat = 3;
    endtask

    task automatic t_init();
        logic [31:0] v;
        sw_init_done = 1;
        hr(8'h40, v); chk("R8 init bit", v, 32'h58);
    endtask

    task automatic t_evt();
        logic [31:0] v;
        @(negedge clk); sw_evt = 13'h208;
        @(negedge clk); sw_evt = 0;
        hr(8'h44, v); chk("R9 latched", v, 32'h208);
        hw(8'h44, 32'h8);
        hr(8'h44, v); chk("R9 w1c", v, 32'h200);
        @(negedge clk);
        h_addr = 8'h44; h_wr = 1; h_wdata = 32'h200; sw_evt = 13'h200;
        @(negedge clk);
        h_wr = 0; sw_evt = 0;
        hr(8'h44, v); chk("R9 set wins over clear", v, 32'h200);
        hw(8'h44, 32'h200);
        hr(8'h44, v); chk("R9 cleared", v, 0);
    endtask

    task automatic t_rst_bit();
        logic [31:0] v;
        hw(8'h2C, 32'h0000_0004);
        chk("R10 sw_reset set", sw_reset, 1);
        hr(8'h2C, v); chk("R10 cmd readback", v, 32'h4);
        @(negedge clk);
        chk("R10 no transaction", req_cnt, 3);
        hw(8'h2C, 32'h0);
        chk("R10 sw_reset cleared", sw_reset, 0);
        hw(8'h40, 32'h0);
        @(negedge clk);
        hr(8'h40, v); chk("R2 released", v, 32'h40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; h_addr = 0; h_wr = 0; h_wdata = 0;
        sw_init_done = 0; sw_evt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_no_grant();
        t_grant();
        t_write();
        t_read();
        t_busy();
        t_init();
        t_evt();
        t_rst_bit();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule